// File: doc/BRIEF.md
# Stair-Step Ramp Converter Controller

This block is the digital side of a counting ramp analog-to-digital converter. A one-cycle start pulse clears an N-bit counter to zero. The counter value drives an external DAC, so the DAC output rises one step per clock like a staircase. A single comparator input reports 1 while that staircase level is still below the analog input. The first code whose level reaches or passes the input ends the conversion. That code is held as the result and an end-of-conversion flag is raised.

The comparator output is asynchronous to the block clock, so it passes through a two-flop synchronizer. Each code that is presented is carried down a short tag pipeline alongside the synchronized compare. When the delayed compare reads 0, the block captures the code that produced it, not the code the counter has since reached, and loads the counter back to that code. The captured code is therefore the smallest code at or above the input. It is not necessarily the nearest code. Conversion time grows with the input: a result of r takes r + 3 clocks. If the ramp reaches all ones while the comparator still reads 1, the ramp stops there and never wraps.

A start pulse that arrives mid-conversion abandons the conversion and restarts from zero. Compare results already in flight are discarded.

Top module: `ramp_adc_ctrl`

## Requirements
- R1: The clock edge that samples `start` high sets `dac_code` to 0, `busy` to 1 and `eoc` to 0.
- R2: While `busy` is high, `dac_code` increases by exactly one per clock until all ones, where it holds.
- R3: With an ideal comparator `ref_below = (dac_code < v)`, the result equals v for 0 <= v <= 2^N-1. This is the smallest code at or above the input.
- R4: When the input exceeds the top code level (v >= 2^N), the ramp does not wrap: the result is all ones.
- R5: `eoc` first reads high after the (r+3)th rising edge that follows the edge sampling `start`, where r is the result. That is two synchronizer clocks plus one decision clock.
- R6: After completion, `busy` is 0, and `eoc`, `result` and `dac_code` (equal to `result`) hold until the next start, whatever the comparator does. `busy` and `eoc` are never high together.
- R7: A start during a conversion aborts it and restarts from zero. The final result depends only on the input seen after the second start.
- R8: After reset, `dac_code`, `result`, `busy` and `eoc` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle start-of-conversion pulse |
| ref_below | input | 1 | Comparator output, asynchronous: 1 while the DAC level is below the input |
| dac_code | output | WIDTH | Code driven to the external DAC |
| busy | output | 1 | Conversion in progress |
| eoc | output | 1 | End of conversion; high until the next start |
| result | output | WIDTH | Held conversion result |

## Verification
The bench builds the block with WIDTH = 4. This keeps the whole input range small enough to sweep every value from 0 up to one past the top code level. Each conversion's result and its exact latency of result + 3 clocks are checked, so both the saturation case and the synchronizer compensation are covered. The short ramp also lets abort-and-restart runs and hold-after-completion runs, with the comparator input changed after completion, finish in a few dozen clocks each.

// File: rtl/ramp_adc_ctrl.sv
module ramp_adc_ctrl #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             ref_below,
  output logic [WIDTH-1:0] dac_code,
  output logic             busy,
  output logic             eoc,
  output logic [WIDTH-1:0] result
);
  localparam logic [WIDTH-1:0] TOP = '1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] tag_q;
  logic [WIDTH-1:0]       code_q [SYNC_STAGES];
  logic [WIDTH-1:0]       cnt;

  wire             cmp_s    = sync_q[SYNC_STAGES-1];
  wire             tag_old  = tag_q[SYNC_STAGES-1];
  wire [WIDTH-1:0] code_old = code_q[SYNC_STAGES-1];
  wire             judge    = busy && tag_old;
  wire             stop     = judge && (!cmp_s || code_old == TOP);

  assign dac_code = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], ref_below};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      busy   <= 1'b0;
      eoc    <= 1'b0;
      result <= '0;
      tag_q  <= '0;
      for (int i = 0; i < SYNC_STAGES; i++) code_q[i] <= '0;
    end else if (start) begin
      cnt   <= '0;
      busy  <= 1'b1;
      eoc   <= 1'b0;
      tag_q <= '0;
    end else begin
      tag_q     <= {tag_q[SYNC_STAGES-2:0], busy};
      code_q[0] <= cnt;
      for (int i = 1; i < SYNC_STAGES; i++) code_q[i] <= code_q[i-1];
      if (stop) begin
        busy   <= 1'b0;
        eoc    <= 1'b1;
        result <= code_old;
        cnt    <= code_old;
      end else if (busy && cnt != TOP) begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

module ramp_adc_ctrl_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [WIDTH-1:0] dac_code,
  input logic             busy,
  input logic             eoc,
  input logic [WIDTH-1:0] result
);
  localparam logic [WIDTH-1:0] TOP = '1;

  a_r1_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (dac_code == '0 && busy && !eoc));

  a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start) |=> (!busy || dac_code == $past(dac_code) + 1'b1 ||
                          (dac_code == TOP && $past(dac_code) == TOP)));

  a_r6_hold_done: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc && !start) |=> (eoc && !busy && $stable(result) && $stable(dac_code)));

  a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && eoc));

  a_r6_code_is_result: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eoc) |-> dac_code == result);

  a_r3_result_bound: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eoc) |-> result <= $past(dac_code));
endmodule

bind ramp_adc_ctrl ramp_adc_ctrl_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .dac_code(dac_code),
  .busy(busy), .eoc(eoc), .result(result)
);

// File: tb/tb_ramp_adc_ctrl.sv
module tb_ramp_adc_ctrl;
  localparam int W   = 4;
  localparam int TOP = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic ref_below;
  logic [W-1:0] dac_code, result;
  logic busy, eoc;
  int vin = 0;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  assign ref_below = (int'(dac_code) < vin);

  ramp_adc_ctrl #(.WIDTH(W), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .ref_below(ref_below),
    .dac_code(dac_code), .busy(busy), .eoc(eoc), .result(result)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_start(input int v);
    @(negedge clk);
    vin = v;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic convert(input int v);
    int exp, n;
    exp = (v > TOP) ? TOP : v;
    pulse_start(v);
    chk(dac_code == 0 && busy && !eoc, "R1 start clears", int'(dac_code), 0);
    n = 0;
    while (!eoc && n < 100) begin
      @(negedge clk);
      n++;
      if (n <= 2) chk(int'(dac_code) == n, "R2 one step per clock", int'(dac_code), n);
    end
    chk(n == exp + 3, "R5 latency", n, exp + 3);
    if (v > TOP) chk(int'(result) == TOP, "R4 saturate no wrap", int'(result), TOP);
    else         chk(int'(result) == exp, "R3 first code at or above", int'(result), exp);
    chk(int'(dac_code) == exp && !busy, "R6 code held at result", int'(dac_code), exp);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(dac_code == 0 && result == 0 && !busy && !eoc, "R8 reset state",
        int'(dac_code) + int'(result) + int'(busy) + int'(eoc), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v <= TOP + 2; v++) convert(v);

    convert(9);
    vin = 0;
    repeat (6) @(negedge clk);
    chk(eoc && int'(result) == 9 && int'(dac_code) == 9, "R6 hold ignores comparator",
        int'(result), 9);
    vin = TOP + 1;
    repeat (6) @(negedge clk);
    chk(eoc && !busy && int'(result) == 9, "R6 hold ignores comparator", int'(result), 9);

    pulse_start(14);
    repeat (5) @(negedge clk);
    chk(busy && !eoc, "R7 first conversion running", int'(busy), 1);
    convert(2);
    chk(int'(result) == 2, "R7 abort restart result", int'(result), 2);

    pulse_start(0);
    convert(11);
    chk(int'(result) == 11, "R7 abort right after start", int'(result), 11);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule